// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a timekeeping core that counts seconds, minutes, hours, day of week, date, month and year in packed BCD. A free-running counter turns a 32.768 kHz clock-enable pulse into a once-per-second tick. On that tick the whole calendar moves forward in one clock cycle. The hours byte can hold either a 24-hour value or a 12-hour value with an AM/PM flag. Month lengths follow the calendar, and February has 29 days in every year whose two-digit value is a multiple of four, which gives correct dates from 2000 through 2099.

A time-of-day alarm compares seconds, minutes, hours and day of week. Each of the four alarm bytes has a mask bit that removes its field from the compare. Masking fields from the day downwards makes the alarm repeat once per day, hour, minute or second. With no mask set it fires once per week. A match sets a status flag. The flag drives an active-high interrupt while the enable bit is set, and reading the status byte clears it. A host loads and reads all bytes through a simple parallel register port, which has a write strobe, a read strobe and a combinational read-data path.

Top module: `rtc_core`

## Requirements
- R1: After reset the block reads seconds 00h, minutes 00h, hours 00h (24-hour mode), day of week 01h, date 01h, month 01h, year 00h. The alarm bytes, control byte (addr 0Bh) and status byte (addr 0Ch) are 00h, and irq_o is 0.
- R2: The seconds value advances once for every DIV_P pulses of tick_en_i. A host write to any time byte (addr 00h–06h) restarts this count, so the next advance comes DIV_P pulses after the write.
- R3: Seconds and minutes count 00–59 in BCD. On a wrap to 00 the next field up advances. For example, 00:59:59 becomes 01:00:00.
- R4: With hours bit 6 = 0 (24-hour mode), hours count 00–23 in BCD. The change from 23 to 00 advances both the date and the day of week.
- R5: With hours bit 6 = 1 (12-hour mode), bits 4:0 count 12, 01, …, 11 in BCD, and bit 5 (1 = PM) toggles on the change from 11 to 12. The date advances only on the change from 11 PM to 12 AM.
- R6: Dates wrap at the end of each month: 30 days for April, June, September and November, 31 for the other long months, and 28 for February, or 29 when the year value is a multiple of four (00 included). Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: Day of week counts 1 to 7 and wraps from 7 to 1.
- R8: Bits with no meaning always read 0. The read masks are seconds/minutes 7Fh, hours 7Fh in 12-hour mode and 3Fh in 24-hour mode, day of week 07h, date 3Fh, month 1Fh, alarm day 87h, and control 01h. Addresses 0Dh–0Fh read 00h.
- R9: The alarm bytes sit at 07h (seconds), 08h (minutes), 09h (hours) and 0Ah (day). Bit 7 of each is a mask. On a tick, status bit 0 is set when every unmasked field equals the time value the tick produces.
- R10: irq_o is high exactly while status bit 0 and control bit 0 are both 1.
- R11: A read strobe at addr 0Ch returns the flag and clears it. If an alarm match happens in the same cycle, the flag stays set.
- R12: When a host write to a time byte happens in the same cycle as a tick, the written value is kept and the calendar does not advance on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | 32.768 kHz time-base enable, one cycle per pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (read-clear side effects) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Alarm interrupt, active high |

## Verification
Two pairs of events can land in the same clock cycle. In the first pair, a status read that clears the flag meets an alarm match that sets it. In the second, a host write to a time byte meets the divider's final enable pulse. The bench produces each pair by counting enable pulses from a write that restarts the divider, so that the read or the write lands exactly on the last pulse. It then checks that the match survives the clear, and that the written byte is kept while the calendar skips that tick and the next advance follows a full DIV_P pulses later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_SEC   = 4'h0;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'h1;
  localparam logic [ADDR_W-1:0] A_HOUR  = 4'h2;
  localparam logic [ADDR_W-1:0] A_DOW   = 4'h3;
  localparam logic [ADDR_W-1:0] A_DATE  = 4'h4;
  localparam logic [ADDR_W-1:0] A_MONTH = 4'h5;
  localparam logic [ADDR_W-1:0] A_YEAR  = 4'h6;
  localparam logic [ADDR_W-1:0] A_ASEC  = 4'h7;
  localparam logic [ADDR_W-1:0] A_AMIN  = 4'h8;
  localparam logic [ADDR_W-1:0] A_AHOUR = 4'h9;
  localparam logic [ADDR_W-1:0] A_ADAY  = 4'hA;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'hB;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'hC;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] dow;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [7:0] bin;
    bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int DIV_P = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV_P > 2) ? $clog2(DIV_P) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_P - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output rtc_time_t         cur_o,
  output rtc_time_t         nxt_o
);
  rtc_time_t cur_q, nxt;
  logic      c_min, c_hour, c_day, c_mon, c_year;
  logic [4:0] h12;
  logic      pm;

  always_comb begin
    nxt    = cur_q;
    c_min  = 1'b0;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_year = 1'b0;
    h12    = cur_q.hour[4:0];
    pm     = cur_q.hour[5];

    if (cur_q.sec == 8'h59) begin nxt.sec = 8'h00; c_min = 1'b1; end
    else nxt.sec = bcd_inc(cur_q.sec);

    if (c_min) begin
      if (cur_q.min == 8'h59) begin nxt.min = 8'h00; c_hour = 1'b1; end
      else nxt.min = bcd_inc(cur_q.min);
    end

    if (c_hour) begin
      if (cur_q.hour[6]) begin
        if (h12 == 5'h12) h12 = 5'h01;
        else if (h12 == 5'h11) begin
          h12   = 5'h12;
          c_day = pm;
          pm    = ~pm;
        end else h12 = 5'(bcd_inc({3'b0, h12}));
        nxt.hour = {2'b01, pm, h12};
      end else begin
        if (cur_q.hour == 8'h23) begin nxt.hour = 8'h00; c_day = 1'b1; end
        else nxt.hour = bcd_inc(cur_q.hour);
      end
    end

    if (c_day) begin
      nxt.dow = (cur_q.dow == 8'h07) ? 8'h01 : cur_q.dow + 8'h01;
      if (cur_q.date == month_len(cur_q.month, cur_q.year)) begin
        nxt.date = 8'h01;
        c_mon    = 1'b1;
      end else nxt.date = bcd_inc(cur_q.date);
    end

    if (c_mon) begin
      if (cur_q.month == 8'h12) begin nxt.month = 8'h01; c_year = 1'b1; end
      else nxt.month = bcd_inc(cur_q.month);
    end

    if (c_year) nxt.year = (cur_q.year == 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
                 date: 8'h01, month: 8'h01, year: 8'h00};
    end else if (we_i && addr_i <= A_YEAR) begin
      case (addr_i)
        A_SEC:   cur_q.sec   <= wdata_i & 8'h7F;
        A_MIN:   cur_q.min   <= wdata_i & 8'h7F;
        A_HOUR:  cur_q.hour  <= wdata_i & (wdata_i[6] ? 8'h7F : 8'h3F);
        A_DOW:   cur_q.dow   <= wdata_i & 8'h07;
        A_DATE:  cur_q.date  <= wdata_i & 8'h3F;
        A_MONTH: cur_q.month <= wdata_i & 8'h1F;
        default: cur_q.year  <= wdata_i;
      endcase
    end else if (tick_i) begin
      cur_q <= nxt;
    end
  end

  assign cur_o = cur_q;
  assign nxt_o = nxt;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  rtc_time_t         nxt_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        asec_o,
  output logic [7:0]        amin_o,
  output logic [7:0]        ahour_o,
  output logic [7:0]        aday_o,
  output logic              irq_en_o,
  output logic              flag_o,
  output logic              set_o
);
  logic [7:0] asec_q, amin_q, ahour_q, aday_q;
  logic       en_q, flag_q, match, clr;

  assign match = (asec_q[7]  || asec_q[6:0]  == nxt_i.sec[6:0])  &&
                 (amin_q[7]  || amin_q[6:0]  == nxt_i.min[6:0])  &&
                 (ahour_q[7] || ahour_q[6:0] == nxt_i.hour[6:0]) &&
                 (aday_q[7]  || aday_q[2:0]  == nxt_i.dow[2:0]);
  assign set_o = tick_i && match;
  assign clr   = re_i && addr_i == A_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asec_q  <= '0;
      amin_q  <= '0;
      ahour_q <= '0;
      aday_q  <= '0;
      en_q    <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        A_ASEC:  asec_q  <= wdata_i;
        A_AMIN:  amin_q  <= wdata_i;
        A_AHOUR: ahour_q <= wdata_i & (wdata_i[6] ? 8'hFF : 8'hBF);
        A_ADAY:  aday_q  <= wdata_i & 8'h87;
        A_CTRL:  en_q    <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // a match in the clearing cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_o || (flag_q && !clr);
  end

  assign asec_o   = asec_q;
  assign amin_o   = amin_q;
  assign ahour_o  = ahour_q;
  assign aday_o   = aday_q;
  assign irq_en_o = en_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int DIV_P = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o
);
  rtc_time_t  cur, nxt;
  logic       sec_tick, time_wr;
  logic [7:0] asec, amin, ahour, aday;
  logic       irq_en, alm_flag, alm_set;

  assign time_wr = reg_we_i && reg_addr_i <= A_YEAR;

  rtc_divider #(.DIV_P(DIV_P)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en_i),
    .clr_i  (time_wr),
    .tick_o (sec_tick)
  );

  rtc_calendar u_cal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sec_tick),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cur_o   (cur),
    .nxt_o   (nxt)
  );

  rtc_alarm u_alm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (sec_tick),
    .nxt_i    (nxt),
    .we_i     (reg_we_i),
    .re_i     (reg_re_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .asec_o   (asec),
    .amin_o   (amin),
    .ahour_o  (ahour),
    .aday_o   (aday),
    .irq_en_o (irq_en),
    .flag_o   (alm_flag),
    .set_o    (alm_set)
  );

  always_comb begin
    case (reg_addr_i)
      A_SEC:   reg_rdata_o = cur.sec;
      A_MIN:   reg_rdata_o = cur.min;
      A_HOUR:  reg_rdata_o = cur.hour;
      A_DOW:   reg_rdata_o = cur.dow;
      A_DATE:  reg_rdata_o = cur.date;
      A_MONTH: reg_rdata_o = cur.month;
      A_YEAR:  reg_rdata_o = cur.year;
      A_ASEC:  reg_rdata_o = asec;
      A_AMIN:  reg_rdata_o = amin;
      A_AHOUR: reg_rdata_o = ahour;
      A_ADAY:  reg_rdata_o = aday;
      A_CTRL:  reg_rdata_o = {7'd0, irq_en};
      A_STAT:  reg_rdata_o = {7'd0, alm_flag};
      default: reg_rdata_o = 8'h00;
    endcase
  end

  assign irq_o = alm_flag && irq_en;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_en_i,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              irq_o,
  input logic              sec_tick,
  input logic [7:0]        cur_sec,
  input logic              alm_flag,
  input logic              alm_set,
  input logic              irq_en
);
  a_r2_tick_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick |-> tick_en_i);

  a_r12_write_blocks_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i <= A_YEAR) |-> !sec_tick);

  a_r3_sec_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick |=> !$stable(cur_sec));

  a_r9_flag_rises_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_flag) |-> $past(sec_tick));

  a_r11_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == A_STAT && !alm_set) |=> !alm_flag);

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_set |=> alm_flag);

  a_r10_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en && alm_flag));
endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_en_i  (tick_en_i),
  .reg_we_i   (reg_we_i),
  .reg_re_i   (reg_re_i),
  .reg_addr_i (reg_addr_i),
  .irq_o      (irq_o),
  .sec_tick   (sec_tick),
  .cur_sec    (cur.sec),
  .alm_flag   (alm_flag),
  .alm_set    (alm_set),
  .irq_en     (irq_en)
);

// File: tb/rtc_core_test.sv
module rtc_core_test;
  localparam int DIV = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_en_i = 1'b0, reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0] reg_addr_i = 4'h0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       irq_o;
  logic [7:0] rd;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;

  rtc_core #(.DIV_P(DIV)) uut (
    .clk_i, .rst_ni, .tick_en_i, .reg_we_i, .reg_re_i,
    .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  task automatic cyc(input logic en, input logic we, input logic re,
                     input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    tick_en_i = en; reg_we_i = we; reg_re_i = re;
    reg_addr_i = a; reg_wdata_i = d;
    #1 rd = reg_rdata_o;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(0, 1, 0, a, d);
  endtask

  task automatic rdreg(input logic [3:0] a);
    cyc(0, 0, 1, a, 8'h00);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    rdreg(a);
    chk(req, rd, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 4'h0, 8'h00);
  endtask

  task automatic settime(input logic [7:0] s, m, h, dw, dt, mo, y);
    wr(4'h6, y); wr(4'h5, mo); wr(4'h4, dt); wr(4'h3, dw);
    wr(4'h2, h); wr(4'h1, m); wr(4'h0, s);
  endtask

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] am [4];
    logic [7:0] nv [4];
    logic       exp_hit;
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values
    rchk("R1 sec", 4'h0, 8'h00); rchk("R1 min", 4'h1, 8'h00);
    rchk("R1 hour", 4'h2, 8'h00); rchk("R1 dow", 4'h3, 8'h01);
    rchk("R1 date", 4'h4, 8'h01); rchk("R1 month", 4'h5, 8'h01);
    rchk("R1 year", 4'h6, 8'h00); rchk("R1 asec", 4'h7, 8'h00);
    rchk("R1 ctrl", 4'hB, 8'h00); rchk("R1 stat", 4'hC, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);

    // R2 divider count from reset
    ticks(DIV - 1); rchk("R2 before", 4'h0, 8'h00);
    ticks(1);       rchk("R2 after", 4'h0, 8'h01);
    ticks(2); wr(4'h1, 8'h10);
    ticks(DIV - 1); rchk("R2 restart hold", 4'h0, 8'h01);
    ticks(1);       rchk("R2 restart adv", 4'h0, 8'h02);

    // R3 carry chain
    settime(8'h59, 8'h59, 8'h00, 8'h02, 8'h10, 8'h05, 8'h20);
    ticks(DIV);
    rchk("R3 sec", 4'h0, 8'h00); rchk("R3 min", 4'h1, 8'h00);
    rchk("R3 hour", 4'h2, 8'h01);

    // R4 / R7 day boundary in 24h mode
    settime(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h20);
    ticks(DIV);
    rchk("R4 hour", 4'h2, 8'h00); rchk("R4 date", 4'h4, 8'h16);
    rchk("R7 dow wrap", 4'h3, 8'h01);

    // R5 12h mode
    settime(8'h59, 8'h59, 8'h51, 8'h03, 8'h10, 8'h05, 8'h20);
    ticks(DIV); rchk("R5 11am->12pm", 4'h2, 8'h72);
    rchk("R5 no date at noon", 4'h4, 8'h10);
    settime(8'h59, 8'h59, 8'h72, 8'h03, 8'h10, 8'h05, 8'h20);
    ticks(DIV); rchk("R5 12pm->1pm", 4'h2, 8'h61);
    settime(8'h59, 8'h59, 8'h71, 8'h03, 8'h10, 8'h05, 8'h20);
    ticks(DIV); rchk("R5 11pm->12am", 4'h2, 8'h52);
    rchk("R5 date at midnight", 4'h4, 8'h11);
    settime(8'h59, 8'h59, 8'h49, 8'h03, 8'h10, 8'h05, 8'h20);
    ticks(DIV); rchk("R5 9->10", 4'h2, 8'h50);

    // R6 month ends and leap years
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    ticks(DIV); rchk("R6 feb23 date", 4'h4, 8'h01); rchk("R6 feb23 month", 4'h5, 8'h03);
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    ticks(DIV); rchk("R6 feb24 29th", 4'h4, 8'h29);
    ticks(DIV * 86400 > 0 ? 0 : 0);
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    ticks(DIV); rchk("R6 feb29 end", 4'h4, 8'h01); rchk("R6 feb29 month", 4'h5, 8'h03);
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    ticks(DIV); rchk("R6 year00 leap", 4'h4, 8'h29);
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h20);
    ticks(DIV); rchk("R6 apr30", 4'h5, 8'h05);
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h20);
    ticks(DIV); rchk("R6 jan30 no wrap", 4'h4, 8'h31);
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    ticks(DIV);
    rchk("R6 dec date", 4'h4, 8'h01); rchk("R6 dec month", 4'h5, 8'h01);
    rchk("R6 year wrap", 4'h6, 8'h00);

    // R8 unused bits
    wr(4'h0, 8'hFF); rchk("R8 sec mask", 4'h0, 8'h7F);
    wr(4'h2, 8'hBF); rchk("R8 hour24 mask", 4'h2, 8'h3F);
    wr(4'h2, 8'hFF); rchk("R8 hour12 mask", 4'h2, 8'h7F);
    wr(4'h3, 8'hFF); rchk("R8 dow mask", 4'h3, 8'h07);
    wr(4'h4, 8'hFF); rchk("R8 date mask", 4'h4, 8'h3F);
    wr(4'h5, 8'hFF); rchk("R8 month mask", 4'h5, 8'h1F);
    wr(4'hA, 8'hFF); rchk("R8 aday mask", 4'hA, 8'h87);
    wr(4'hB, 8'hFF); rchk("R8 ctrl mask", 4'hB, 8'h01);
    wr(4'hD, 8'hFF); rchk("R8 unmapped", 4'hD, 8'h00);
    wr(4'hB, 8'h00);

    // R9 directed: seconds-only match
    wr(4'h7, 8'h05); wr(4'h8, 8'h80); wr(4'h9, 8'h80); wr(4'hA, 8'h80);
    settime(8'h03, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h20);
    rdreg(4'hC);
    ticks(DIV); rchk("R9 no match", 4'hC, 8'h00);
    ticks(DIV); rchk("R9 match", 4'hC, 8'h01);
    rchk("R11 cleared", 4'hC, 8'h00);

    // R9 random masks and values
    for (int it = 0; it < 24; it++) begin
      int s, m, h, d;
      s = int'($urandom % 59); m = int'($urandom % 60);
      h = int'($urandom % 24); d = int'($urandom % 7) + 1;
      nv[0] = bcd(s + 1); nv[1] = bcd(m); nv[2] = bcd(h); nv[3] = bcd(d);
      for (int f = 0; f < 4; f++) begin
        logic [7:0] v;
        v = ($urandom % 2 == 0) ? nv[f] : bcd(int'($urandom % (f == 3 ? 7 : 24)) + (f == 3 ? 1 : 0));
        am[f] = {1'($urandom % 2), v[6:0]};
      end
      am[3] = am[3] & 8'h87;
      exp_hit = 1'b1;
      for (int f = 0; f < 4; f++)
        if (!am[f][7] && am[f][6:0] != nv[f][6:0]) exp_hit = 1'b0;
      wr(4'h7, am[0]); wr(4'h8, am[1]); wr(4'h9, am[2]); wr(4'hA, am[3]);
      settime(bcd(s), bcd(m), bcd(h), bcd(d), 8'h01, 8'h01, 8'h20);
      rdreg(4'hC);
      ticks(DIV);
      rchk("R9 random", 4'hC, {7'd0, exp_hit});
    end

    // R10 interrupt gating
    wr(4'h7, 8'h80); wr(4'h8, 8'h80); wr(4'h9, 8'h80); wr(4'hA, 8'h80);
    wr(4'hB, 8'h00);
    settime(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h20);
    ticks(DIV); cyc(0, 0, 0, 4'h0, 8'h00);
    chk("R10 irq disabled", {7'd0, irq_o}, 8'h00);
    wr(4'hB, 8'h01); cyc(0, 0, 0, 4'h0, 8'h00);
    chk("R10 irq enabled", {7'd0, irq_o}, 8'h01);
    rchk("R10 flag seen", 4'hC, 8'h01);
    cyc(0, 0, 0, 4'h0, 8'h00);
    chk("R10 irq after clear", {7'd0, irq_o}, 8'h00);

    // R11 clear and match in the same cycle
    settime(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h20);
    rdreg(4'hC);
    ticks(DIV - 1);
    cyc(1, 0, 1, 4'hC, 8'h00);
    chk("R11 old value on read", rd, 8'h00);
    cyc(0, 0, 0, 4'h0, 8'h00);
    chk("R11 irq kept", {7'd0, irq_o}, 8'h01);
    rchk("R11 set wins", 4'hC, 8'h01);

    // R12 write on the tick cycle
    settime(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h20);
    ticks(DIV - 1);
    cyc(1, 1, 0, 4'h0, 8'h30);
    rchk("R12 write kept", 4'h0, 8'h30);
    rchk("R12 min unchanged", 4'h1, 8'h00);
    ticks(DIV - 1); rchk("R12 full second", 4'h0, 8'h30);
    ticks(1);       rchk("R12 advance", 4'h0, 8'h31);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1673));
  end
endmodule